// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block tracks the position of the serial stream, as bit and word slot, from a one-cycle bit strobe, and derives from that position a frame sync, the current slot index and a one-cycle word-done strobe. The word length, a 5-bit divide field, a normal/network mode choice and a bit-long/word-long sync choice set the framing. In network mode the divide field gives the slots per frame minus one. A divide field of zero in network mode turns on on-demand framing, where a frame is produced only after a request. In normal mode the divide field sets how often a data word is transferred, and only slot 0 of each frame carries one.

The control inputs are copied into an active configuration only at a frame boundary, so a setting changed mid-frame takes effect at the next frame. Reset clears the active configuration and leaves the generator idle until the first bit strobe, which opens slot 0. The block raises an error flag when the active configuration pairs normal mode, divide-by-one and word-long sync, which is an illegal combination.

Top module: `fsg_top`

## Requirements
- R1: While reset is low and after its release, up to the first bit strobe, fsync, word_done and cfg_err are 0 and slot_idx is 0. Reset clears the active configuration.
- R2: The control inputs (word_bits, frame_div, net_mode, word_sync) are captured only at the first strobe after reset and at the strobe that ends the last bit of the last slot. A change between those points has no effect until the next boundary.
- R3: Each bit strobe advances one bit. A word is word_bits strobes long, with 0 treated as 1. slot_idx increments at each word end and wraps from frame_div to 0. The state changes only on strobe cycles.
- R4: With word_sync=0 and not on-demand, fsync is high during the last bit of slot frame_div and low at all other times.
- R5: With word_sync=1 and not on-demand, fsync is high during the whole of slot 0.
- R6: In network mode (net_mode=1, frame_div>=1), word_done is high for exactly the one cycle after the strobe that ends each slot.
- R7: In normal mode (net_mode=0), word_done fires only after the strobe that ends slot 0.
- R8: In normal mode with frame_div=0, every word is its own frame: a bit-long sync marks the last bit of every word, and word_done follows every word.
- R9: cfg_err is 1 exactly while the active configuration is normal mode, frame_div=0 and word_sync=1. It changes only in the cycle after a frame boundary.
- R10: In network mode with frame_div=0 (on-demand), slot_idx stays 0, and without a request fsync and word_done stay 0.
- R11: In on-demand mode, od_req is sampled on strobe cycles. A request sampled at a strobe that does not end a word, or at the strobe that ends the previous word, marks the word in progress. A marked word raises the bit-long sync during its last bit, and the word after it is then framed. A framed word holds the word-long sync for its whole length and produces word_done when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe per serial bit |
| word_bits | input | 6 | Bits per word (0 treated as 1) |
| frame_div | input | 5 | Divide field, frame ratio = value + 1 |
| net_mode | input | 1 | 1 = network mode, 0 = normal mode |
| word_sync | input | 1 | 1 = word-long sync, 0 = bit-long sync |
| od_req | input | 1 | On-demand frame request, sampled with bit_stb |
| fsync | output | 1 | Frame sync |
| slot_idx | output | 5 | Current slot index |
| word_done | output | 1 | One-cycle strobe after a transferred word ends |
| cfg_err | output | 1 | Illegal active configuration |

## Verification
All state moves on the rising edge that samples bit_stb. slot_idx and fsync therefore show their new values in the cycle right after the strobe cycle and hold until the next strobe. word_done is high only in that one following cycle, and cfg_err updates in the cycle after a boundary strobe. The bench drives each strobe for one cycle from a falling edge and reads every output at the next falling edge. It then idles one cycle and reads again to confirm that word_done has dropped and the other outputs have held.

// File: rtl/fsg_pkg.sv
`timescale 1ns/1ps
// Shared widths and types for the frame sync generator.
// Assumes: divide field and slot index share one width.
package fsg_pkg;
    localparam int DIV_W  = 5;
    localparam int WL_W   = 6;
    localparam int SLOT_W = DIV_W;

    typedef enum logic {MODE_NORMAL = 1'b0, MODE_NETWORK = 1'b1} fs_mode_e;
    typedef enum logic {SYNC_BIT = 1'b0, SYNC_WORD = 1'b1} fs_len_e;

    typedef struct packed {
        fs_mode_e         mode;
        fs_len_e          len;
        logic [DIV_W-1:0] div;
        logic [WL_W-1:0]  wl;
    } fs_cfg_t;
endpackage

// File: rtl/fsg_cfg_shadow.sv
`timescale 1ns/1ps
// Active configuration register. Loads the requested settings on a
// frame boundary and decodes the derived controls from the held copy.
// Assumes: load is a single-cycle pulse from the word counter.
module fsg_cfg_shadow
    import fsg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  fs_cfg_t         cfg_d,
    output fs_cfg_t         cfg_q,
    output logic [WL_W-1:0] last_bit_idx,
    output logic            on_demand,
    output logic            bad_combo
);
    // Hold the active settings; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_d;
    end

    // Decode the last bit index, the on-demand case and the illegal pairing.
    always_comb begin
        last_bit_idx = (cfg_q.wl == '0) ? '0 : cfg_q.wl - 1'b1;
        on_demand    = (cfg_q.mode == MODE_NETWORK) && (cfg_q.div == '0);
        bad_combo    = (cfg_q.mode == MODE_NORMAL) && (cfg_q.div == '0)
                       && (cfg_q.len == SYNC_WORD);
    end
endmodule

// File: rtl/fsg_word_counter.sv
`timescale 1ns/1ps
// Bit and slot position counters. The first strobe after reset opens
// slot 0 bit 0. Each later strobe advances the bit, and a strobe in the
// last bit ends the word and advances the slot, wrapping after div_lim.
// Assumes: last_bit_idx and div_lim come from the active configuration.
module fsg_word_counter
    import fsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic [WL_W-1:0]   last_bit_idx,
    input  logic [DIV_W-1:0]  div_lim,
    output logic              started,
    output logic [SLOT_W-1:0] slot_q,
    output logic              last_bit,
    output logic              last_slot,
    output logic              word_end,
    output logic              frame_bound
);
    logic [WL_W-1:0] bit_cnt_q;

    // Position decode and boundary events for this cycle.
    always_comb begin
        last_bit    = (bit_cnt_q == last_bit_idx);
        last_slot   = (slot_q == div_lim);
        word_end    = bit_stb && started && last_bit;
        frame_bound = bit_stb && (!started || (last_bit && last_slot));
    end

    // Advance the bit and slot position on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started   <= 1'b0;
            bit_cnt_q <= '0;
            slot_q    <= '0;
        end else if (frame_bound) begin
            started   <= 1'b1;
            bit_cnt_q <= '0;
            slot_q    <= '0;
        end else if (word_end) begin
            bit_cnt_q <= '0;
            slot_q    <= slot_q + 1'b1;
        end else if (bit_stb) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (slot_q <= div_lim)); // R3
    AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> ($stable(slot_q) && $stable(bit_cnt_q))); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && last_slot) |=> (slot_q == '0)); // R3
endmodule

// File: rtl/fsg_sync_gen.sv
`timescale 1ns/1ps
// Frame sync and word-done generation from the counter position and the
// active configuration, including the on-demand request tracking.
// Assumes: od_req is only meaningful on bit strobe cycles.
module fsg_sync_gen
    import fsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              od_req,
    input  logic              started,
    input  logic              word_end,
    input  logic              frame_bound,
    input  logic              last_bit,
    input  logic              last_slot,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              on_demand,
    input  logic              net,
    input  logic              word_len,
    output logic              fsync,
    output logic              word_done
);
    logic pending_q;
    logic armed_q;

    // Track requests: pending marks the current word, armed the framed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            armed_q   <= 1'b0;
        end else if (bit_stb) begin
            if (frame_bound && !started) begin
                pending_q <= od_req;
                armed_q   <= 1'b0;
            end else if (word_end) begin
                armed_q   <= pending_q;
                pending_q <= od_req;
            end else begin
                pending_q <= pending_q | od_req;
            end
        end
    end

    // Register the word-done strobe for words that carry data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_done <= 1'b0;
        else
            word_done <= word_end &&
                         (on_demand ? armed_q : (net || (slot_idx == '0)));
    end

    // Select the sync shape from the mode and the sync length.
    always_comb begin
        if (!started)
            fsync = 1'b0;
        else if (on_demand)
            fsync = word_len ? armed_q : (pending_q && last_bit);
        else
            fsync = word_len ? (slot_idx == '0) : (last_bit && last_slot);
    end

    AST_OD_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        (started && on_demand) |-> (slot_idx == '0)); // R10
    AST_WD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> $past(bit_stb)); // R6
    AST_NORMAL_WD_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !$past(net)) |-> ($past(slot_idx) == '0)); // R7
endmodule

// File: rtl/fsg_top.sv
`timescale 1ns/1ps
// Programmable frame sync generator top. Ties the active configuration,
// the position counters and the sync decode together.
// Assumes: bit_stb is a one-cycle pulse per serial bit in the clk domain.
module fsg_top
    import fsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic [WL_W-1:0]   word_bits,
    input  logic [DIV_W-1:0]  frame_div,
    input  logic              net_mode,
    input  logic              word_sync,
    input  logic              od_req,
    output logic              fsync,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              word_done,
    output logic              cfg_err
);
    fs_cfg_t         cfg_d;
    fs_cfg_t         cfg_q;
    logic [WL_W-1:0] last_bit_idx;
    logic            on_demand;
    logic            started;
    logic            last_bit;
    logic            last_slot;
    logic            word_end;
    logic            frame_bound;

    // Pack the requested settings for the shadow register.
    always_comb begin
        cfg_d.mode = net_mode ? MODE_NETWORK : MODE_NORMAL;
        cfg_d.len  = word_sync ? SYNC_WORD : SYNC_BIT;
        cfg_d.div  = frame_div;
        cfg_d.wl   = word_bits;
    end

    fsg_cfg_shadow u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (frame_bound),
        .cfg_d        (cfg_d),
        .cfg_q        (cfg_q),
        .last_bit_idx (last_bit_idx),
        .on_demand    (on_demand),
        .bad_combo    (cfg_err)
    );

    fsg_word_counter u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_stb      (bit_stb),
        .last_bit_idx (last_bit_idx),
        .div_lim      (cfg_q.div),
        .started      (started),
        .slot_q       (slot_idx),
        .last_bit     (last_bit),
        .last_slot    (last_slot),
        .word_end     (word_end),
        .frame_bound  (frame_bound)
    );

    fsg_sync_gen u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .od_req      (od_req),
        .started     (started),
        .word_end    (word_end),
        .frame_bound (frame_bound),
        .last_bit    (last_bit),
        .last_slot   (last_slot),
        .slot_idx    (slot_idx),
        .on_demand   (on_demand),
        .net         (cfg_q.mode == MODE_NETWORK),
        .word_len    (cfg_q.len == SYNC_WORD),
        .fsync       (fsync),
        .word_done   (word_done)
    );

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_bound |=> $stable(cfg_q)); // R2
    AST_ERR_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_err) |-> $past(frame_bound)); // R9
endmodule

// File: tb/sim_fsg_top.sv
`timescale 1ns/1ps
module sim_fsg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic [5:0] word_bits = '0;
    logic [4:0] frame_div = '0;
    logic       net_mode = 1'b0;
    logic       word_sync = 1'b0;
    logic       od_req = 1'b0;
    logic       fsync;
    logic [4:0] slot_idx;
    logic       word_done;
    logic       cfg_err;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fsg_top u0 (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .word_bits(word_bits),
        .frame_div(frame_div), .net_mode(net_mode), .word_sync(word_sync),
        .od_req(od_req), .fsync(fsync), .slot_idx(slot_idx),
        .word_done(word_done), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic       net;
        logic [4:0] div;
        logic       word;
        logic [5:0] wl;
        logic       err;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b0, 5'd2,  1'b0, 6'd3, 1'b0},
        '{1'b0, 5'd3,  1'b1, 6'd2, 1'b0},
        '{1'b1, 5'd3,  1'b0, 6'd4, 1'b0},
        '{1'b1, 5'd1,  1'b1, 6'd3, 1'b0},
        '{1'b0, 5'd0,  1'b0, 6'd3, 1'b0},
        '{1'b0, 5'd0,  1'b1, 6'd2, 1'b1},
        '{1'b1, 5'd31, 1'b0, 6'd1, 1'b0},
        '{1'b0, 5'd0,  1'b0, 6'd0, 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic n, input logic [4:0] d,
                            input logic w, input logic [5:0] l);
        rst_n = 1'b0;
        net_mode = n; frame_div = d; word_sync = w; word_bits = l;
        repeat (3) @(negedge clk);
        check("R1 fsync in reset", fsync, 0);
        check("R1 slot in reset", slot_idx, 0);
        check("R1 word_done in reset", word_done, 0);
        check("R1 cfg_err in reset", cfg_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle fsync", fsync, 0);
        check("R1 idle cfg_err", cfg_err, 0);
    endtask

    // One strobe cycle, leaving time at the sample point after its edge.
    task automatic strobe(input logic req);
        bit_stb = 1'b1; od_req = req;
        @(negedge clk);
        bit_stb = 1'b0; od_req = 1'b0;
    endtask

    task automatic gap();
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            strobe(1'b0);
            gap();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // Table walk: R3..R9 over several configurations.
        for (int v = 0; v < NVEC; v++) begin
            vec_t cv;
            int w;
            int r;
            string ftag;
            string wtag;
            cv = VECS[v];
            w = (cv.wl == 0) ? 1 : int'(cv.wl);
            r = int'(cv.div) + 1;
            ftag = (!cv.net && cv.div == 0) ? "R8 fsync" : (cv.word ? "R5 fsync" : "R4 fsync");
            wtag = cv.net ? "R6 word_done" : (cv.div == 0 ? "R8 word_done" : "R7 word_done");
            do_reset(cv.net, cv.div, cv.word, cv.wl);
            for (int p = 0; p < r * w * 2 + 1; p++) begin
                int b;
                int s;
                int ef;
                int ewd;
                strobe(1'b0);
                b = p % w;
                s = (p / w) % r;
                ef = cv.word ? int'(s == 0) : int'(b == w - 1 && s == r - 1);
                ewd = int'(p > 0 && (p % w) == 0 && (cv.net || ((p / w - 1) % r) == 0));
                check("R3 slot_idx", slot_idx, s);
                check(ftag, fsync, ef);
                check(wtag, word_done, ewd);
                if (p == 0) check("R9 cfg_err", cfg_err, cv.err);
                gap();
                check("R6 word_done one cycle", word_done, 0);
                check("R3 slot hold", slot_idx, s);
            end
        end

        // R2: mid-frame change waits for the frame boundary.
        do_reset(1'b0, 5'd3, 1'b0, 6'd2);
        run(2);
        frame_div = 5'd1; word_bits = 6'd3;
        run(5);
        strobe(1'b0);
        check("R2 old ratio slot", slot_idx, 3);
        check("R2 old ratio fsync", fsync, 1);
        gap();
        strobe(1'b0);
        check("R2 boundary slot", slot_idx, 0);
        gap();
        run(1);
        strobe(1'b0);
        check("R2 new length slot", slot_idx, 0);
        gap();
        strobe(1'b0);
        check("R2 new length slot1", slot_idx, 1);
        gap();
        run(1);
        strobe(1'b0);
        check("R2 new ratio fsync", fsync, 1);
        gap();
        strobe(1'b0);
        check("R2 new ratio wrap", slot_idx, 0);
        gap();

        // R10: on-demand without requests stays quiet.
        do_reset(1'b1, 5'd0, 1'b0, 6'd4);
        for (int p = 0; p < 8; p++) begin
            strobe(1'b0);
            check("R10 slot", slot_idx, 0);
            check("R10 fsync", fsync, 0);
            check("R10 word_done", word_done, 0);
            gap();
        end

        // R11: request mid-word, bit-long sync.
        do_reset(1'b1, 5'd0, 1'b0, 6'd4);
        strobe(1'b0); gap();
        strobe(1'b1); gap();
        strobe(1'b0); gap();
        strobe(1'b0);
        check("R11 bit sync on marked word", fsync, 1);
        gap();
        strobe(1'b0);
        check("R11 bit sync drops", fsync, 0);
        check("R11 no done for marked word", word_done, 0);
        gap();
        run(3);
        strobe(1'b0);
        check("R11 done after framed word", word_done, 1);
        gap();

        // R11: request mid-word, word-long sync.
        do_reset(1'b1, 5'd0, 1'b1, 6'd4);
        strobe(1'b0); gap();
        strobe(1'b1); gap();
        run(1);
        strobe(1'b0);
        check("R11 word sync before framed word", fsync, 0);
        gap();
        strobe(1'b0);
        check("R11 word sync rises", fsync, 1);
        gap();
        run(2);
        strobe(1'b0);
        check("R11 word sync holds", fsync, 1);
        gap();
        strobe(1'b0);
        check("R11 word sync falls", fsync, 0);
        check("R11 word sync done", word_done, 1);
        gap();

        // R11: request at a word end marks the following word.
        do_reset(1'b1, 5'd0, 1'b0, 6'd2);
        strobe(1'b0); gap();
        strobe(1'b0);
        check("R11 no sync before request", fsync, 0);
        gap();
        strobe(1'b1);
        check("R11 first bit of marked word", fsync, 0);
        gap();
        strobe(1'b0);
        check("R11 sync after word-end request", fsync, 1);
        gap();

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule